// File: doc/BRIEF.md
# Host Memory Window Decoder

This block sorts every host memory address into one of four targets. The first is a legacy banked frame-buffer window in the low megabyte. The second is a 16 MiB linear frame-buffer aperture and the third a 256 KiB register aperture. The last is a 32 KiB expansion ROM window. For each target the decoder drives a hit flag and a target-local offset. All decoding is combinational. The only state is a small bank-select register that the host writes through a byte port.

Two inputs set the legacy window. A two-bit map-select field chooses where the window sits and how large it is. The bank register then adds an offset in 8 KiB steps, counted from 1, to the masked address inside that window. A single memory-enable input gates the legacy, linear and register targets. The ROM window is gated only by its own enable. When programmed windows overlap, a fixed priority keeps the hits mutually exclusive.

Top module: `mem_window_dec`

## Requirements
- R1: The legacy window depends on map_sel_i. Value 0 covers 0xA0000 to 0xBFFFF, value 1 covers 0xA0000 to 0xAFFFF, value 2 covers 0xB0000 to 0xB7FFF, and value 3 covers 0xB8000 to 0xBFFFF. Addresses outside the selected range do not give a legacy hit.
- R2: The legacy offset is (addr & mask) + bank offset. The mask is 0xFFFF for map values 0 and 1 and 0x7FFF for values 2 and 3. The write bank offset is used when host_wr_i is 1 and the read bank offset otherwise.
- R3: When mem_en_i is 0, leg_hit_o, lin_hit_o and reg_hit_o are all 0.
- R4: lin_hit_o is raised when addr_i[31:24] equals lin_base_i. lin_off_o is addr_i[23:0].
- R5: The register aperture hits when addr_i[31:18] equals reg_base_i. reg_off_o is addr_i[17:0].
- R6: The ROM window hits when rom_en_i is 1 and addr_i[31:15] equals rom_base_i, whatever the value of mem_en_i. rom_off_o is addr_i[14:0].
- R7: A bank write (bank_wr_i=1, bank_ofs_i=0x72) with a nonzero byte N sets both rd_bank_o and wr_bank_o to (N-1)<<13 one clock later. bank_val_o then reads N.
- R8: A bank write of 0 to offset 0x72 sets bank_val_o to 0 and leaves rd_bank_o and wr_bank_o unchanged.
- R9: Bank writes to any offset other than 0x72 change none of bank_val_o, rd_bank_o or wr_bank_o.
- R10: At most one hit output is 1 at any time. The priority order is legacy, then register, then linear, then ROM.
- R11: After reset, bank_val_o, rd_bank_o and wr_bank_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the bank register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Host byte address |
| host_wr_i | input | 1 | Access is a write (selects the write bank) |
| map_sel_i | input | 2 | Legacy window map select |
| mem_en_i | input | 1 | Memory decode enable |
| lin_base_i | input | 8 | Linear aperture base, address bits 31:24 |
| reg_base_i | input | 14 | Register aperture base, address bits 31:18 |
| rom_en_i | input | 1 | ROM window enable |
| rom_base_i | input | 17 | ROM window base, address bits 31:15 |
| bank_wr_i | input | 1 | Bank port byte write strobe |
| bank_ofs_i | input | 8 | Bank port byte offset |
| bank_data_i | input | 8 | Bank port write data |
| leg_hit_o | output | 1 | Legacy window hit |
| leg_off_o | output | 22 | Legacy window offset |
| lin_hit_o | output | 1 | Linear aperture hit |
| lin_off_o | output | 24 | Linear aperture offset |
| reg_hit_o | output | 1 | Register aperture hit |
| reg_off_o | output | 18 | Register aperture offset |
| rom_hit_o | output | 1 | ROM window hit |
| rom_off_o | output | 15 | ROM window offset |
| bank_val_o | output | 8 | Last byte stored in the bank register |
| rd_bank_o | output | 21 | Read bank offset |
| wr_bank_o | output | 21 | Write bank offset |

## Verification
The assertions check several properties on every cycle. Hits are always mutually exclusive, and memory-enable gating holds. A legacy hit never falls outside 0xA0000 to 0xBFFFF. A linear hit always matches its base, and a ROM hit requires its enable. For the bank register, the assertions check the update after a nonzero write, that the offsets hold after a zero write, and that nothing moves without an addressed write. The bench scenarios cover the rest. They check the exact window edges for each map select and the offset arithmetic at the largest bank value. They also cover aperture boundaries and the priority outcome when windows are programmed to overlap.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int unsigned LEG_AW = 20;
  localparam logic [7:0] BANK_REG_OFS = 8'h72;

  typedef enum logic [1:0] {
    MAP_A0_128K = 2'b00,
    MAP_A0_64K  = 2'b01,
    MAP_B0_32K  = 2'b10,
    MAP_B8_32K  = 2'b11
  } leg_map_e;

  typedef struct packed {
    logic [LEG_AW-1:0] lo;   // inclusive
    logic [LEG_AW-1:0] hi;   // exclusive
    logic [15:0]       mask;
  } leg_win_t;

  function automatic leg_win_t leg_window(leg_map_e m);
    leg_win_t w;
    case (m)
      MAP_A0_128K: w = '{lo: 20'hA0000, hi: 20'hC0000, mask: 16'hFFFF};
      MAP_A0_64K:  w = '{lo: 20'hA0000, hi: 20'hB0000, mask: 16'hFFFF};
      MAP_B0_32K:  w = '{lo: 20'hB0000, hi: 20'hB8000, mask: 16'h7FFF};
      default:     w = '{lo: 20'hB8000, hi: 20'hC0000, mask: 16'h7FFF};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/win_legacy_dec.sv
module win_legacy_dec
  import win_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BANK_OFF_W = 21,
  localparam int unsigned OFF_W     = BANK_OFF_W + 1
) (
  input  logic                  en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [1:0]            map_sel_i,
  input  logic [BANK_OFF_W-1:0] bank_off_i,
  output logic                  hit_o,
  output logic [OFF_W-1:0]      off_o
);
  leg_win_t win;
  logic     low_mb;
  logic     in_rng;

  always_comb begin
    win    = leg_window(leg_map_e'(map_sel_i));
    low_mb = (addr_i[ADDR_W-1:LEG_AW] == '0);
    in_rng = (addr_i[LEG_AW-1:0] >= win.lo) && (addr_i[LEG_AW-1:0] < win.hi);
    hit_o  = en_i && low_mb && in_rng;
    off_o  = OFF_W'(addr_i[15:0] & win.mask) + OFF_W'(bank_off_i);
  end
endmodule

// File: rtl/win_aperture.sv
module win_aperture #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_LOG2 = 24,
  localparam int unsigned BASE_W   = ADDR_W - SIZE_LOG2
) (
  input  logic                 en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BASE_W-1:0]    base_i,
  output logic                 hit_o,
  output logic [SIZE_LOG2-1:0] off_o
);
  assign hit_o = en_i && (addr_i[ADDR_W-1:SIZE_LOG2] == base_i);
  assign off_o = addr_i[SIZE_LOG2-1:0];
endmodule

// File: rtl/win_bank_reg.sv
module win_bank_reg
  import win_pkg::*;
#(
  parameter int unsigned BANK_W     = 8,
  parameter int unsigned BANK_SHIFT = 13,
  localparam int unsigned BANK_OFF_W = BANK_W + BANK_SHIFT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [7:0]            wr_ofs_i,
  input  logic [BANK_W-1:0]     wr_data_i,
  output logic [BANK_W-1:0]     bank_val_o,
  output logic [BANK_OFF_W-1:0] rd_bank_o,
  output logic [BANK_OFF_W-1:0] wr_bank_o
);
  logic load;
  logic nonzero;
  logic [BANK_OFF_W-1:0] new_off;

  assign load    = wr_i && (wr_ofs_i == BANK_REG_OFS);
  assign nonzero = (wr_data_i != '0);
  assign new_off = {wr_data_i - BANK_W'(1), {BANK_SHIFT{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_val_o <= '0;
      rd_bank_o  <= '0;
      wr_bank_o  <= '0;
    end else if (load) begin
      bank_val_o <= wr_data_i;
      if (nonzero) begin
        rd_bank_o <= new_off;
        wr_bank_o <= new_off;
      end
    end
  end

  p_bank_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && nonzero) |=> (rd_bank_o == wr_bank_o) && (bank_val_o == $past(wr_data_i))
                          && (rd_bank_o[BANK_SHIFT-1:0] == '0));

  p_bank_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !nonzero) |=> (bank_val_o == '0) && $stable(rd_bank_o) && $stable(wr_bank_o));

  p_bank_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(bank_val_o) && $stable(rd_bank_o) && $stable(wr_bank_o));
endmodule

// File: rtl/mem_window_dec.sv
module mem_window_dec
  import win_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIN_LOG2   = 24,
  parameter int unsigned REG_LOG2   = 18,
  parameter int unsigned ROM_LOG2   = 15,
  parameter int unsigned BANK_W     = 8,
  parameter int unsigned BANK_SHIFT = 13,
  localparam int unsigned BANK_OFF_W = BANK_W + BANK_SHIFT,
  localparam int unsigned LEG_OFF_W  = BANK_OFF_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       host_wr_i,
  input  logic [1:0]                 map_sel_i,
  input  logic                       mem_en_i,
  input  logic [ADDR_W-LIN_LOG2-1:0] lin_base_i,
  input  logic [ADDR_W-REG_LOG2-1:0] reg_base_i,
  input  logic                       rom_en_i,
  input  logic [ADDR_W-ROM_LOG2-1:0] rom_base_i,
  input  logic                       bank_wr_i,
  input  logic [7:0]                 bank_ofs_i,
  input  logic [BANK_W-1:0]          bank_data_i,
  output logic                       leg_hit_o,
  output logic [LEG_OFF_W-1:0]       leg_off_o,
  output logic                       lin_hit_o,
  output logic [LIN_LOG2-1:0]        lin_off_o,
  output logic                       reg_hit_o,
  output logic [REG_LOG2-1:0]        reg_off_o,
  output logic                       rom_hit_o,
  output logic [ROM_LOG2-1:0]        rom_off_o,
  output logic [BANK_W-1:0]          bank_val_o,
  output logic [BANK_OFF_W-1:0]      rd_bank_o,
  output logic [BANK_OFF_W-1:0]      wr_bank_o
);
  logic leg_raw, lin_raw, reg_raw, rom_raw;
  logic [BANK_OFF_W-1:0] bank_sel;

  win_bank_reg #(.BANK_W(BANK_W), .BANK_SHIFT(BANK_SHIFT)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bank_wr_i),
    .wr_ofs_i  (bank_ofs_i),
    .wr_data_i (bank_data_i),
    .bank_val_o(bank_val_o),
    .rd_bank_o (rd_bank_o),
    .wr_bank_o (wr_bank_o)
  );

  assign bank_sel = host_wr_i ? wr_bank_o : rd_bank_o;

  win_legacy_dec #(.ADDR_W(ADDR_W), .BANK_OFF_W(BANK_OFF_W)) u_leg (
    .en_i      (mem_en_i),
    .addr_i    (addr_i),
    .map_sel_i (map_sel_i),
    .bank_off_i(bank_sel),
    .hit_o     (leg_raw),
    .off_o     (leg_off_o)
  );

  win_aperture #(.ADDR_W(ADDR_W), .SIZE_LOG2(LIN_LOG2)) u_lin (
    .en_i(mem_en_i), .addr_i(addr_i), .base_i(lin_base_i), .hit_o(lin_raw), .off_o(lin_off_o)
  );

  win_aperture #(.ADDR_W(ADDR_W), .SIZE_LOG2(REG_LOG2)) u_reg (
    .en_i(mem_en_i), .addr_i(addr_i), .base_i(reg_base_i), .hit_o(reg_raw), .off_o(reg_off_o)
  );

  // ROM decode is not gated by the memory enable
  win_aperture #(.ADDR_W(ADDR_W), .SIZE_LOG2(ROM_LOG2)) u_rom (
    .en_i(rom_en_i), .addr_i(addr_i), .base_i(rom_base_i), .hit_o(rom_raw), .off_o(rom_off_o)
  );

  // fixed priority: legacy > register > linear > rom
  always_comb begin
    leg_hit_o = leg_raw;
    reg_hit_o = reg_raw && !leg_raw;
    lin_hit_o = lin_raw && !leg_raw && !reg_raw;
    rom_hit_o = rom_raw && !leg_raw && !reg_raw && !lin_raw;
  end

  p_one_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({leg_hit_o, reg_hit_o, lin_hit_o, rom_hit_o}));

  p_mem_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |-> !leg_hit_o && !lin_hit_o && !reg_hit_o);

  p_leg_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_hit_o |-> (addr_i >= ADDR_W'(32'hA0000)) && (addr_i < ADDR_W'(32'hC0000)));

  p_lin_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_hit_o |-> (addr_i[ADDR_W-1:LIN_LOG2] == lin_base_i));

  p_rom_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_hit_o |-> rom_en_i);
endmodule

// File: tb/mem_window_dec_tb.sv
module mem_window_dec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        host_wr_i = 1'b0;
  logic [1:0]  map_sel_i = '0;
  logic        mem_en_i = 1'b1;
  logic [7:0]  lin_base_i = 8'hFF;
  logic [13:0] reg_base_i = 14'h3FFF;
  logic        rom_en_i = 1'b0;
  logic [16:0] rom_base_i = '0;
  logic        bank_wr_i = 1'b0;
  logic [7:0]  bank_ofs_i = '0;
  logic [7:0]  bank_data_i = '0;
  logic        leg_hit_o, lin_hit_o, reg_hit_o, rom_hit_o;
  logic [21:0] leg_off_o;
  logic [23:0] lin_off_o;
  logic [17:0] reg_off_o;
  logic [14:0] rom_off_o;
  logic [7:0]  bank_val_o;
  logic [20:0] rd_bank_o, wr_bank_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_window_dec u_dut (
    .clk_i, .rst_ni, .addr_i, .host_wr_i, .map_sel_i, .mem_en_i, .lin_base_i,
    .reg_base_i, .rom_en_i, .rom_base_i, .bank_wr_i, .bank_ofs_i, .bank_data_i,
    .leg_hit_o, .leg_off_o, .lin_hit_o, .lin_off_o, .reg_hit_o, .reg_off_o,
    .rom_hit_o, .rom_off_o, .bank_val_o, .rd_bank_o, .wr_bank_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic probe(logic [31:0] a);
    @(negedge clk_i);
    addr_i = a;
    #1;
  endtask

  task automatic bank_write(logic [7:0] ofs, logic [7:0] data);
    @(negedge clk_i);
    bank_wr_i = 1'b1; bank_ofs_i = ofs; bank_data_i = data;
    @(negedge clk_i);
    bank_wr_i = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R11 bank_val", 32'(bank_val_o), 0);
    chk("R11 rd_bank", 32'(rd_bank_o), 0);
    chk("R11 wr_bank", 32'(wr_bank_o), 0);
  endtask

  task automatic t_legacy_maps;
    map_sel_i = 2'd0;
    probe(32'h9FFFF); chk("R1 map0 below", 32'(leg_hit_o), 0);
    probe(32'hA0000); chk("R1 map0 low", 32'(leg_hit_o), 1); chk("R2 map0 off", 32'(leg_off_o), 0);
    probe(32'hBFFFF); chk("R1 map0 top", 32'(leg_hit_o), 1); chk("R2 map0 alias", 32'(leg_off_o), 32'hFFFF);
    probe(32'hC0000); chk("R1 map0 above", 32'(leg_hit_o), 0);
    map_sel_i = 2'd1;
    probe(32'hAFFFF); chk("R1 map1 top", 32'(leg_hit_o), 1);
    probe(32'hB0000); chk("R1 map1 above", 32'(leg_hit_o), 0);
    map_sel_i = 2'd2;
    probe(32'hAFFFF); chk("R1 map2 below", 32'(leg_hit_o), 0);
    probe(32'hB7FFF); chk("R1 map2 top", 32'(leg_hit_o), 1); chk("R2 map2 off", 32'(leg_off_o), 32'h7FFF);
    probe(32'hB8000); chk("R1 map2 above", 32'(leg_hit_o), 0);
    map_sel_i = 2'd3;
    probe(32'hB8000); chk("R1 map3 low", 32'(leg_hit_o), 1); chk("R2 map3 off", 32'(leg_off_o), 0);
    probe(32'hBFFFF); chk("R2 map3 top off", 32'(leg_off_o), 32'h7FFF);
    probe(32'h100A0000); chk("R1 high alias", 32'(leg_hit_o), 0);
    map_sel_i = 2'd0;
  endtask

  task automatic t_bank;
    bank_write(8'h72, 8'd3);
    chk("R7 val", 32'(bank_val_o), 3);
    chk("R7 rd", 32'(rd_bank_o), 32'h4000);
    chk("R7 wr", 32'(wr_bank_o), 32'h4000);
    probe(32'hA0010); chk("R2 banked rd", 32'(leg_off_o), 32'h4010);
    host_wr_i = 1'b1; #1; chk("R2 banked wr", 32'(leg_off_o), 32'h4010); host_wr_i = 1'b0;
    bank_write(8'h72, 8'd0);
    chk("R8 val", 32'(bank_val_o), 0);
    chk("R8 rd kept", 32'(rd_bank_o), 32'h4000);
    chk("R8 wr kept", 32'(wr_bank_o), 32'h4000);
    bank_write(8'h71, 8'd9);
    chk("R9 val", 32'(bank_val_o), 0);
    chk("R9 rd", 32'(rd_bank_o), 32'h4000);
    bank_write(8'h73, 8'd9);
    chk("R9 wr", 32'(wr_bank_o), 32'h4000);
    bank_write(8'h72, 8'd1);
    chk("R7 one", 32'(rd_bank_o), 0);
    bank_write(8'h72, 8'hFF);
    chk("R7 max", 32'(rd_bank_o), 32'h1FC000);
    probe(32'hBFFFF); chk("R2 max off", 32'(leg_off_o), 32'h20BFFF);
    bank_write(8'h72, 8'd1);
  endtask

  task automatic t_linear;
    lin_base_i = 8'h12;
    probe(32'h12345678); chk("R4 hit", 32'(lin_hit_o), 1); chk("R4 off", 32'(lin_off_o), 32'h345678);
    probe(32'h12FFFFFF); chk("R4 top", 32'(lin_hit_o), 1);
    probe(32'h13000000); chk("R4 above", 32'(lin_hit_o), 0);
    probe(32'h11FFFFFF); chk("R4 below", 32'(lin_hit_o), 0);
  endtask

  task automatic t_regs;
    reg_base_i = 14'h0801;
    probe(32'h2007FFFC); chk("R5 hit", 32'(reg_hit_o), 1); chk("R5 off", 32'(reg_off_o), 32'h3FFFC);
    probe(32'h20040000); chk("R5 low", 32'(reg_hit_o), 1);
    probe(32'h20080000); chk("R5 above", 32'(reg_hit_o), 0);
  endtask

  task automatic t_rom;
    rom_base_i = 17'h00018; rom_en_i = 1'b1;
    probe(32'hC7FFF); chk("R6 hit", 32'(rom_hit_o), 1); chk("R6 off", 32'(rom_off_o), 32'h7FFF);
    probe(32'hC8000); chk("R6 above", 32'(rom_hit_o), 0);
    rom_en_i = 1'b0;
    probe(32'hC0000); chk("R6 disabled", 32'(rom_hit_o), 0);
  endtask

  task automatic t_mem_disable;
    mem_en_i = 1'b0; rom_en_i = 1'b1;
    probe(32'hA0000); chk("R3 legacy", 32'(leg_hit_o), 0);
    probe(32'h12000000); chk("R3 linear", 32'(lin_hit_o), 0);
    probe(32'h20040000); chk("R3 reg", 32'(reg_hit_o), 0);
    probe(32'hC0000); chk("R6 rom no memen", 32'(rom_hit_o), 1);
    mem_en_i = 1'b1; rom_en_i = 1'b0;
  endtask

  task automatic t_priority;
    reg_base_i = 14'h0002; lin_base_i = 8'h00; rom_base_i = 17'h0; rom_en_i = 1'b1;
    map_sel_i = 2'd0;
    probe(32'hA0000);
    chk("R10 leg wins", 32'({leg_hit_o, reg_hit_o, lin_hit_o, rom_hit_o}), 32'b1000);
    probe(32'h90000);
    chk("R10 reg wins", 32'({leg_hit_o, reg_hit_o, lin_hit_o, rom_hit_o}), 32'b0100);
    probe(32'h00000100);
    chk("R10 lin wins", 32'({leg_hit_o, reg_hit_o, lin_hit_o, rom_hit_o}), 32'b0010);
    lin_base_i = 8'hFF;
    probe(32'h00000100);
    chk("R10 rom alone", 32'({leg_hit_o, reg_hit_o, lin_hit_o, rom_hit_o}), 32'b0001);
    rom_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset;
    rst_ni = 1'b1;
    t_legacy_maps;
    t_bank;
    t_linear;
    t_regs;
    t_rom;
    t_mem_disable;
    t_priority;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule